// File: doc/BRIEF.md
# Duplicated Adder with Two-Phase Sampling and Majority Vote

This block adds two unsigned operands in a way that tolerates a single transient fault. It combines hardware redundancy with time redundancy. Two identical adder copies work on the same registered operands. The output of each copy is captured in two consecutive clock cycles, which gives four samples in total.

A judging stage inspects the four samples and forms a trusted value. A bitwise two-out-of-three vote is then taken over the later sample of copy 0, the later sample of copy 1 and the trusted value. The voted sum is registered in the third cycle after the operands are loaded.

Each copy has a fault-injection mask input. Every set bit of a mask flips the matching bit of that copy's sum, so a transient can be placed in any chosen sampling cycle.

Top module: `dup_timevote_adder`

## Requirements
- R1: After synchronous reset, `done` is 0, `mismatch` is 0 and `sum` is 0.
- R2: With zero fault masks, `sum` equals `opa + opb` over WIDTH+1 bits. The carry-out is at bit WIDTH. `mismatch` is 0. `done` rises in the third clock cycle after the edge that samples `go`.
- R3: `done` is high for exactly one cycle per operation.
- R4: A `go` asserted while an operation is in progress is ignored: the operands are not reloaded and no extra `done` pulse appears.
- R5: A mask on copy 0 during the first sampling cycle (the cycle after the `go` edge) still yields the correct sum, with `mismatch` = 1.
- R6: A mask on either copy during the second sampling cycle still yields the correct sum, with `mismatch` = 1.
- R7: A mask on copy 1 during the first sampling cycle still yields the correct sum, with `mismatch` = 1.
- R8: Masks on copy 0 in the first sampling cycle and on copy 1 in the second still yield the correct sum, with `mismatch` = 1.
- R9: The same mask on copy 0 in both sampling cycles makes copy 0 self-consistent but different from copy 1. The result is then copy 0's value, `(opa+opb) ^ mask`, with `mismatch` = 1.
- R10: Masks applied outside the two sampling cycles have no effect on `sum` or `mismatch`.
- R11: `sum` and `mismatch` hold their values after `done` falls, until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Starts an operation when idle |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| flip0 | input | WIDTH+1 | Fault mask XORed onto the output of copy 0 |
| flip1 | input | WIDTH+1 | Fault mask XORed onto the output of copy 1 |
| done | output | 1 | One-cycle pulse when a result is ready |
| sum | output | WIDTH+1 | Voted sum |
| mismatch | output | 1 | Some sample disagreed with the voted sum |

## Verification
The timing is fixed:
- The edge that samples `go` loads the operands.
- The next edge captures the first pair of samples.
- The edge after that captures the second pair.
- A third edge registers `sum`, `mismatch` and `done`.

The bench drives every input on the falling edge. Masks are placed one per falling edge, so each mask lands in exactly one chosen phase. The bench reads the outputs on the fourth falling edge after raising `go`, where `done` must be high. It reads them again one falling edge later to confirm that `done` has dropped and the result is held.

// File: rtl/dtv_pkg.sv
package dtv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMP_T = 2'd1,
        PH_SAMP_D = 2'd2,
        PH_VOTE   = 2'd3
    } phase_e;

    typedef struct packed {
        logic load;
        logic cap_t;
        logic cap_d;
        logic cap_out;
    } ctrl_s;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/dtv_ctrl.sv
module dtv_ctrl
    import dtv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    output phase_e phase_o,
    output ctrl_s  ctl_o
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   phase_q <= go ? PH_SAMP_T : PH_IDLE;
                PH_SAMP_T: phase_q <= PH_SAMP_D;
                PH_SAMP_D: phase_q <= PH_VOTE;
                PH_VOTE:   phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.load    = (phase_q == PH_IDLE) && go;
        ctl_o.cap_t   = (phase_q == PH_SAMP_T);
        ctl_o.cap_d   = (phase_q == PH_SAMP_D);
        ctl_o.cap_out = (phase_q == PH_VOTE);
    end

    assign phase_o = phase_q;

    // R4: a go seen while busy never restarts the sequence
    p_busy_ignores_go_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_VOTE) |=> (phase_q != PH_SAMP_T));

    // R2: the phase sequence advances one step per cycle once started
    p_sequence_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SAMP_T) |=> (phase_q == PH_SAMP_D));

endmodule

// File: rtl/dtv_copy.sv
module dtv_copy #(
    parameter int WIDTH = 16,
    localparam int SW = WIDTH + 1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [SW-1:0]    flip,
    output logic [SW-1:0]    s
);
    logic [SW-1:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        s   = raw ^ flip;
    end
endmodule

// File: rtl/dtv_samples.sv
module dtv_samples #(
    parameter int SW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_t,
    input  logic          cap_d,
    input  logic [SW-1:0] din,
    output logic [SW-1:0] smp_t,
    output logic [SW-1:0] smp_d
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_t <= '0;
            smp_d <= '0;
        end else begin
            if (cap_t) smp_t <= din;
            if (cap_d) smp_d <= din;
        end
    end
endmodule

// File: rtl/dtv_judge.sv
module dtv_judge
    import dtv_pkg::*;
#(
    parameter int SW = 17
) (
    input  logic [SW-1:0] c0_t,
    input  logic [SW-1:0] c0_d,
    input  logic [SW-1:0] c1_t,
    input  logic [SW-1:0] c1_d,
    output logic [SW-1:0] voted,
    output logic          disagree
);
    logic          c0_ok;
    logic          c1_ok;
    logic [SW-1:0] trusted;

    always_comb begin
        c0_ok = (c0_t == c0_d);
        c1_ok = (c1_t == c1_d);
        if (c0_ok)      trusted = c0_d;
        else if (c1_ok) trusted = c1_d;
        else            trusted = c0_d;
    end

    for (genvar i = 0; i < SW; i++) begin : g_vote
        assign voted[i] = maj3(c0_d[i], c1_d[i], trusted[i]);
    end

    assign disagree = (c0_t != voted) || (c0_d != voted) ||
                      (c1_t != voted) || (c1_d != voted);

    // R2: four identical samples give that value without a flag
    always_comb begin
        if (c0_t == c1_t && c0_d == c1_d && c0_t == c0_d) begin
            a_clean_r2: assert (voted == c0_d && !disagree);
        end
    end
endmodule

// File: rtl/dup_timevote_adder.sv
module dup_timevote_adder
    import dtv_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int SW = WIDTH + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [SW-1:0]    flip0,
    input  logic [SW-1:0]    flip1,
    output logic             done,
    output logic [SW-1:0]    sum,
    output logic             mismatch
);
    phase_e            phase;
    ctrl_s             ctl;
    logic [WIDTH-1:0]  a_q;
    logic [WIDTH-1:0]  b_q;
    logic [SW-1:0]     flips  [2];
    logic [SW-1:0]     cp_out [2];
    logic [SW-1:0]     s_t    [2];
    logic [SW-1:0]     s_d    [2];
    logic [SW-1:0]     voted;
    logic              disagree;

    assign flips[0] = flip0;
    assign flips[1] = flip1;

    dtv_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .phase_o (phase),
        .ctl_o   (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (ctl.load) begin
            a_q <= opa;
            b_q <= opb;
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_copy
        dtv_copy #(.WIDTH(WIDTH)) u_copy (
            .a    (a_q),
            .b    (b_q),
            .flip (flips[k]),
            .s    (cp_out[k])
        );
        dtv_samples #(.SW(SW)) u_smp (
            .clk   (clk),
            .rst   (rst),
            .cap_t (ctl.cap_t),
            .cap_d (ctl.cap_d),
            .din   (cp_out[k]),
            .smp_t (s_t[k]),
            .smp_d (s_d[k])
        );
    end

    dtv_judge #(.SW(SW)) u_judge (
        .c0_t     (s_t[0]),
        .c0_d     (s_d[0]),
        .c1_t     (s_t[1]),
        .c1_d     (s_d[1]),
        .voted    (voted),
        .disagree (disagree)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            sum      <= '0;
            mismatch <= 1'b0;
        end else begin
            done <= ctl.cap_out;
            if (ctl.cap_out) begin
                sum      <= voted;
                mismatch <= disagree;
            end
        end
    end

    // R3: completion pulse lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: operands are frozen while samples are taken
    p_operands_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SAMP_T) |=> ($stable(a_q) && $stable(b_q)));

    // R2: a clean result is the true sum of the held operands
    p_clean_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !mismatch) |-> (sum == ({1'b0, a_q} + {1'b0, b_q})));

    // R11: outputs hold between completions
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!ctl.cap_out) |=> ($stable(sum) && $stable(mismatch)));

endmodule

// File: tb/test_dup_timevote_adder.sv
module test_dup_timevote_adder;
    localparam int W  = 16;
    localparam int SW = W + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          go;
    logic [W-1:0]  opa, opb;
    logic [SW-1:0] flip0, flip1;
    logic          done, mismatch;
    logic [SW-1:0] sum;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dup_timevote_adder #(.WIDTH(W)) i_dup_timevote_adder (
        .clk(clk), .rst(rst), .go(go), .opa(opa), .opb(opb),
        .flip0(flip0), .flip1(flip1),
        .done(done), .sum(sum), .mismatch(mismatch)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One operation; masks given per phase: first sample, second sample, vote cycle.
    task automatic run_op(input string req,
                          input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [SW-1:0] f0t, input logic [SW-1:0] f1t,
                          input logic [SW-1:0] f0d, input logic [SW-1:0] f1d,
                          input logic [SW-1:0] fv,
                          input logic [SW-1:0] exp_sum, input logic exp_mis);
        @(negedge clk); go = 1'b1; opa = a; opb = b;
        @(negedge clk); go = 1'b0; flip0 = f0t; flip1 = f1t;
        chk({req, " done early"}, 64'(done), 64'd0);
        @(negedge clk); flip0 = f0d; flip1 = f1d;
        @(negedge clk); flip0 = fv; flip1 = fv;
        @(negedge clk); flip0 = '0; flip1 = '0;
        chk({req, " done"}, 64'(done), 64'd1);
        chk({req, " sum"}, 64'(sum), 64'(exp_sum));
        chk({req, " mismatch"}, 64'(mismatch), 64'(exp_mis));
        @(negedge clk);
        chk({req, " R3 done falls"}, 64'(done), 64'd0);
        chk({req, " R11 sum held"}, 64'(sum), 64'(exp_sum));
        chk({req, " R11 mismatch held"}, 64'(mismatch), 64'(exp_mis));
    endtask

    function automatic logic [SW-1:0] add(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic t_reset;
        rst = 1'b1; go = 1'b0; opa = '0; opb = '0; flip0 = '0; flip1 = '0;
        repeat (3) @(negedge clk);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 sum", 64'(sum), 64'd0);
        chk("R1 mismatch", 64'(mismatch), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_clean;
        run_op("R2 plain", 16'd1234, 16'd4321, 0, 0, 0, 0, 0, add(16'd1234, 16'd4321), 1'b0);
        run_op("R2 carry", 16'hFFFF, 16'h0001, 0, 0, 0, 0, 0, 17'h10000, 1'b0);
        run_op("R2 max", 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 17'h1FFFE, 1'b0);
    endtask

    task automatic t_busy_go;
        // R4: second go during the first sampling phase must be ignored
        @(negedge clk); go = 1'b1; opa = 16'd100; opb = 16'd23;
        @(negedge clk); go = 1'b1; opa = 16'd7; opb = 16'd7;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0; opa = '0; opb = '0;
        @(negedge clk);
        chk("R4 done", 64'(done), 64'd1);
        chk("R4 sum from first operands", 64'(sum), 64'd123);
        @(negedge clk);
        chk("R4 no extra done", 64'(done), 64'd0);
        @(negedge clk);
        chk("R4 still no done", 64'(done), 64'd0);
    endtask

    task automatic t_faults;
        logic [W-1:0] a = 16'h3A5C, b = 16'h1234;
        logic [SW-1:0] good = add(16'h3A5C, 16'h1234);
        run_op("R5 copy0 first",  a, b, 17'h00101, 0, 0, 0, 0, good, 1'b1);
        run_op("R6 copy0 second", a, b, 0, 0, 17'h10001, 0, 0, good, 1'b1);
        run_op("R6 copy1 second", a, b, 0, 0, 0, 17'h0FFFF, 0, good, 1'b1);
        run_op("R7 copy1 first",  a, b, 0, 17'h08000, 0, 0, 0, good, 1'b1);
        run_op("R8 split phases", a, b, 17'h000F0, 0, 0, 17'h00F00, 0, good, 1'b1);
        run_op("R9 copy0 steady", a, b, 17'h00030, 0, 17'h00030, 0, 0, good ^ 17'h00030, 1'b1);
        run_op("R10 vote-cycle mask", a, b, 0, 0, 0, 0, 17'h1FFFF, good, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_clean();
                t_busy_go();
                t_faults();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule